// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Monitor

This block keeps the single reservation that a 32-bit big-endian core sets up with a word load-and-reserve and consumes with the matching store-conditional. A reserve request records which aligned 128-byte line was reserved and whether the reservation was taken at word or doubleword size. A store-conditional request supplies the base and index operands, a flag saying the base field is register zero (so the base reads as a literal zero), the word to store and the current summary-overflow bit. The block forms the effective address and checks it against the reservation. It then either issues one 32-bit memory write or reports failure through a 4-bit condition-field result.

Stores seen from other agents and context switches arrive on a snoop port and cancel the reservation. Every store-conditional attempt consumes the reservation, so a retry loop has to begin with a new reserve. A misaligned store-conditional raises a fault instead of a result. All results are registered, and each appears on the outputs exactly one clock after the request.

Top module: `lrsc_monitor`

## Requirements
- R1: The effective address is `sc_index + (sc_base_zero ? 0 : sc_base)`, truncated to 32 bits, and a committed write carries it on `wr_addr`.
- R2: A store-conditional matches the reservation when address bits [31:7] of the effective address equal those of the reserve address. Any word inside the same aligned 128-byte line therefore matches.
- R3: A reservation taken with `rsv_dword`=1 (doubleword) never lets a store-conditional commit.
- R4: On success, `wr_en` pulses one cycle after the request with `wr_data` = `sc_data`, the big-endian word whose bits [31:24] go to the lowest byte address. On failure, `wr_en` stays low.
- R5: Every aligned store-conditional raises `cr0_we` one cycle later. `cr0` is then {LT,GT,EQ,SO} in bits 3..0, with LT=0, GT=0, EQ=success and SO=`sc_so`.
- R6: Every store-conditional attempt, whether it succeeds or fails, clears the reservation. A second attempt without a new reserve fails.
- R7: A snoop store whose address lies in the reserved line clears the reservation. A snoop store to any other line leaves it intact.
- R8: If effective-address bits [1:0] are not zero, `align_fault` pulses one cycle later. There is no write, `cr0_we` stays low, `cr0` holds its value, and the reservation is cleared.
- R9: `ctx_switch` clears the reservation unconditionally.
- R10: A snoop hit on the reserved line, or a context switch, in the same cycle as a store-conditional makes that store-conditional fail.
- R11: A reserve request replaces any existing reservation in one cycle, setting the line, the width and the valid flag. When a reserve request and a store-conditional arrive in the same cycle, the store-conditional is judged against the old reservation and the new one is kept.
- R12: After reset no reservation is held and `wr_en`, `cr0_we`, `align_fault` and `cr0` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rsv_req | input | 1 | Record a new reservation |
| rsv_addr | input | 32 | Address of the reserving load |
| rsv_dword | input | 1 | 1 = doubleword reservation, 0 = word |
| sc_req | input | 1 | Store-conditional request |
| sc_base_zero | input | 1 | Base field is zero: use literal 0 as base |
| sc_base | input | 32 | Base operand |
| sc_index | input | 32 | Index operand |
| sc_data | input | 32 | Low 32 bits of the source register |
| sc_so | input | 1 | Incoming summary-overflow bit |
| snoop_store | input | 1 | Store by another agent observed |
| snoop_addr | input | 32 | Address of that store |
| ctx_switch | input | 1 | Context switch: drop the reservation |
| wr_en | output | 1 | Memory write strobe (one cycle) |
| wr_addr | output | 32 | Write address |
| wr_data | output | 32 | Write data, big-endian word |
| cr0_we | output | 1 | Condition field result valid |
| cr0 | output | 4 | {LT,GT,EQ,SO} |
| align_fault | output | 1 | Misaligned store-conditional |

## Verification
A request presented before clock edge N produces `wr_en`, `cr0_we`, `cr0` and `align_fault` at edge N itself. A reserve, snoop or context switch at edge N changes what a store-conditional sees from the following cycle onward. The bench drives every input half a cycle before an edge and pushes one expected item per driven cycle, idle cycles included. A monitor pops and compares one item shortly after each rising edge, so every result is checked in exactly the cycle it is due, and a result that comes early or late counts as a mismatch.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  localparam logic [3:0] WIDTH_NONE  = 4'd0;
  localparam logic [3:0] WIDTH_WORD  = 4'd4;
  localparam logic [3:0] WIDTH_DWORD = 4'd8;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cr_field_t;
endpackage

// File: rtl/lrsc_ea.sv
module lrsc_ea #(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic              base_zero,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] index,
  output logic [ADDR_W-1:0] ea,
  output logic              misaligned
);
  localparam int ALIGN_W = $clog2(WORD_BYTES);

  logic [ADDR_W-1:0] base_eff;

  always_comb begin
    base_eff   = base_zero ? '0 : base;
    ea         = base_eff + index;
    misaligned = (ea[ALIGN_W-1:0] != '0);
  end
endmodule

// File: rtl/lrsc_resv.sv
module lrsc_resv
  import lrsc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   rsv_req,
  input  logic [ADDR_W-1:0]                      rsv_addr,
  input  logic                                   rsv_dword,
  input  logic                                   sc_attempt,
  input  logic                                   snoop_store,
  input  logic [ADDR_W-1:0]                      snoop_addr,
  input  logic                                   ctx_switch,
  output logic                                   resv_valid,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]   resv_line,
  output logic [3:0]                             resv_width,
  output logic                                   snoop_hit
);
  localparam int OFS_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFS_W;

  logic              valid_q;
  logic [LINE_W-1:0] line_q;
  logic [3:0]        width_q;

  assign snoop_hit  = snoop_store && valid_q && (snoop_addr[ADDR_W-1:OFS_W] == line_q);
  assign resv_valid = valid_q;
  assign resv_line  = line_q;
  assign resv_width = width_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      line_q  <= '0;
      width_q <= WIDTH_NONE;
    end else if (rsv_req) begin
      valid_q <= 1'b1;
      line_q  <= rsv_addr[ADDR_W-1:OFS_W];
      width_q <= rsv_dword ? WIDTH_DWORD : WIDTH_WORD;
    end else if (sc_attempt || snoop_hit || ctx_switch) begin
      valid_q <= 1'b0;
      width_q <= WIDTH_NONE;
    end
  end
endmodule

// File: rtl/lrsc_commit.sv
module lrsc_commit
  import lrsc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 128
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 sc_req,
  input  logic [ADDR_W-1:0]                    ea,
  input  logic                                 misaligned,
  input  logic [DATA_W-1:0]                    sc_data,
  input  logic                                 sc_so,
  input  logic                                 resv_valid,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0] resv_line,
  input  logic [3:0]                           resv_width,
  input  logic                                 snoop_hit,
  input  logic                                 ctx_switch,
  output logic                                 wr_en,
  output logic [ADDR_W-1:0]                    wr_addr,
  output logic [DATA_W-1:0]                    wr_data,
  output logic                                 cr0_we,
  output cr_field_t                            cr0,
  output logic                                 align_fault
);
  localparam int OFS_W = $clog2(LINE_BYTES);

  logic line_match;
  logic width_ok;
  logic success;

  always_comb begin
    line_match = (ea[ADDR_W-1:OFS_W] == resv_line);
    width_ok   = (resv_width == WIDTH_WORD);
    success    = resv_valid && width_ok && line_match && !snoop_hit && !ctx_switch;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en       <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= '0;
      cr0_we      <= 1'b0;
      cr0         <= '0;
      align_fault <= 1'b0;
    end else begin
      wr_en       <= 1'b0;
      cr0_we      <= 1'b0;
      align_fault <= 1'b0;
      if (sc_req) begin
        if (misaligned) begin
          align_fault <= 1'b1;
        end else begin
          cr0_we  <= 1'b1;
          cr0     <= '{lt: 1'b0, gt: 1'b0, eq: success, so: sc_so};
          wr_en   <= success;
          wr_addr <= ea;
          wr_data <= sc_data;
        end
      end
    end
  end
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
  import lrsc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 128,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rsv_req,
  input  logic [31:0]       rsv_addr,
  input  logic              rsv_dword,
  input  logic              sc_req,
  input  logic              sc_base_zero,
  input  logic [31:0]       sc_base,
  input  logic [31:0]       sc_index,
  input  logic [31:0]       sc_data,
  input  logic              sc_so,
  input  logic              snoop_store,
  input  logic [31:0]       snoop_addr,
  input  logic              ctx_switch,
  output logic              wr_en,
  output logic [31:0]       wr_addr,
  output logic [31:0]       wr_data,
  output logic              cr0_we,
  output logic [3:0]        cr0,
  output logic              align_fault
);
  localparam int OFS_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0] ea;
  logic              misaligned;
  logic              resv_valid;
  logic [LINE_W-1:0] resv_line;
  logic [3:0]        resv_width;
  logic              snoop_hit;
  cr_field_t         cr0_s;

  lrsc_ea #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_ea (
    .base_zero (sc_base_zero),
    .base      (sc_base),
    .index     (sc_index),
    .ea        (ea),
    .misaligned(misaligned)
  );

  lrsc_resv #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_resv (
    .clk        (clk),
    .rst        (rst),
    .rsv_req    (rsv_req),
    .rsv_addr   (rsv_addr),
    .rsv_dword  (rsv_dword),
    .sc_attempt (sc_req),
    .snoop_store(snoop_store),
    .snoop_addr (snoop_addr),
    .ctx_switch (ctx_switch),
    .resv_valid (resv_valid),
    .resv_line  (resv_line),
    .resv_width (resv_width),
    .snoop_hit  (snoop_hit)
  );

  lrsc_commit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES)) u_commit (
    .clk        (clk),
    .rst        (rst),
    .sc_req     (sc_req),
    .ea         (ea),
    .misaligned (misaligned),
    .sc_data    (sc_data),
    .sc_so      (sc_so),
    .resv_valid (resv_valid),
    .resv_line  (resv_line),
    .resv_width (resv_width),
    .snoop_hit  (snoop_hit),
    .ctx_switch (ctx_switch),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .cr0_we     (cr0_we),
    .cr0        (cr0_s),
    .align_fault(align_fault)
  );

  assign cr0 = cr0_s;
endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              rsv_req,
  input logic              sc_req,
  input logic              snoop_store,
  input logic [31:0]       snoop_addr,
  input logic              ctx_switch,
  input logic [ADDR_W-1:0] ea,
  input logic              wr_en,
  input logic [31:0]       wr_addr,
  input logic              cr0_we,
  input logic [3:0]        cr0,
  input logic              align_fault
);
  localparam int OFS_W = $clog2(LINE_BYTES);

  p_write_aligned_r1: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr[1:0] == 2'b00));

  p_write_means_eq_r4: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (cr0_we && cr0[1]));

  p_cr_lt_gt_zero_r5: assert property (@(posedge clk) disable iff (rst)
    cr0_we |-> (cr0[3:2] == 2'b00));

  p_drop_after_attempt_r6: assert property (@(posedge clk) disable iff (rst)
    (sc_req && !rsv_req) ##1 sc_req |=> !wr_en);

  p_fault_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    align_fault |-> (!wr_en && !cr0_we));

  p_ctx_drops_r9: assert property (@(posedge clk) disable iff (rst)
    (ctx_switch && !rsv_req) ##1 sc_req |=> !wr_en);

  p_snoop_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (sc_req && snoop_store && (snoop_addr[ADDR_W-1:OFS_W] == ea[ADDR_W-1:OFS_W])) |=> !wr_en);
endmodule

bind lrsc_monitor lrsc_monitor_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rsv_req    (rsv_req),
  .sc_req     (sc_req),
  .snoop_store(snoop_store),
  .snoop_addr (snoop_addr),
  .ctx_switch (ctx_switch),
  .ea         (ea),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .cr0_we     (cr0_we),
  .cr0        (cr0),
  .align_fault(align_fault)
);

// File: tb/sim_lrsc_monitor.sv
`timescale 1ns/1ps
module sim_lrsc_monitor;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rsv_req = 0, rsv_dword = 0, sc_req = 0, sc_base_zero = 0, sc_so = 0;
  logic snoop_store = 0, ctx_switch = 0;
  logic [31:0] rsv_addr = 0, sc_base = 0, sc_index = 0, sc_data = 0, snoop_addr = 0;
  logic wr_en, cr0_we, align_fault;
  logic [31:0] wr_addr, wr_data;
  logic [3:0] cr0;

  always #10 clk = ~clk;

  lrsc_monitor u0 (
    .clk(clk), .rst(rst), .rsv_req(rsv_req), .rsv_addr(rsv_addr), .rsv_dword(rsv_dword),
    .sc_req(sc_req), .sc_base_zero(sc_base_zero), .sc_base(sc_base), .sc_index(sc_index),
    .sc_data(sc_data), .sc_so(sc_so), .snoop_store(snoop_store), .snoop_addr(snoop_addr),
    .ctx_switch(ctx_switch), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cr0_we(cr0_we), .cr0(cr0), .align_fault(align_fault)
  );

  typedef struct {
    string       tag;
    logic        wr;
    logic [31:0] addr;
    logic [31:0] data;
    logic        crwe;
    logic [3:0]  cr;
    logic        fault;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench-side reservation view, built from the requirements
  logic        m_valid = 0;
  logic [24:0] m_line  = 0;
  logic        m_dw    = 0;

  task automatic drive(input string tag,
                       input logic rq, input logic [31:0] ra, input logic rdw,
                       input logic sc, input logic bz, input logic [31:0] b,
                       input logic [31:0] ix, input logic [31:0] d, input logic so,
                       input logic snp, input logic [31:0] sa, input logic cx);
    exp_t e;
    logic [31:0] ea;
    logic hit, ok;
    @(negedge clk);
    rsv_req = rq; rsv_addr = ra; rsv_dword = rdw;
    sc_req = sc; sc_base_zero = bz; sc_base = b; sc_index = ix; sc_data = d; sc_so = so;
    snoop_store = snp; snoop_addr = sa; ctx_switch = cx;
    ea  = (bz ? 32'd0 : b) + ix;
    hit = snp && m_valid && (sa[31:7] == m_line);
    e.tag = tag; e.wr = 0; e.addr = ea; e.data = d; e.crwe = 0; e.cr = 0; e.fault = 0;
    if (sc) begin
      if (ea[1:0] != 2'b00) e.fault = 1;
      else begin
        ok = m_valid && !m_dw && (ea[31:7] == m_line) && !hit && !cx;
        e.crwe = 1; e.cr = {2'b00, ok, so}; e.wr = ok;
      end
    end
    q.push_back(e);
    if (rq) begin m_valid = 1; m_line = ra[31:7]; m_dw = rdw; end
    else if (sc || hit || cx) begin m_valid = 0; m_dw = 0; end
  endtask

  task automatic idle(input string tag);
    drive(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic reserve(input string tag, input logic [31:0] a, input logic dw);
    drive(tag, 1, a, dw, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic sc(input string tag, input logic bz, input logic [31:0] b,
                    input logic [31:0] ix, input logic [31:0] d, input logic so);
    drive(tag, 0, 0, 0, 1, bz, b, ix, d, so, 0, 0, 0);
  endtask
  task automatic snoop(input string tag, input logic [31:0] a);
    drive(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, a, 0);
  endtask

  // Monitor: one expected item per driven cycle, compared after the edge
  always @(posedge clk) begin
    #2;
    if (!rst && q.size() > 0) begin
      exp_t e;
      bit bad;
      e = q.pop_front();
      bad = (wr_en !== e.wr) || (cr0_we !== e.crwe) || (align_fault !== e.fault)
         || (e.wr && (wr_addr !== e.addr || wr_data !== e.data))
         || (e.crwe && cr0 !== e.cr);
      checks++;
      if (bad) begin
        errors++;
        $display("FAIL %s: got wr=%0b addr=%h data=%h crwe=%0b cr=%b fault=%0b, expected wr=%0b addr=%h data=%h crwe=%0b cr=%b fault=%0b",
                 e.tag, wr_en, wr_addr, wr_data, cr0_we, cr0, align_fault,
                 e.wr, e.addr, e.data, e.crwe, e.cr, e.fault);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin @(posedge clk); cyc++; end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion within 5000 cycles");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R12: reset state at the ports
    checks++;
    if (wr_en !== 0 || cr0_we !== 0 || align_fault !== 0 || cr0 !== 4'b0000) begin
      errors++;
      $display("FAIL R12: got wr=%0b crwe=%0b fault=%0b cr=%b, expected all zero",
               wr_en, cr0_we, align_fault, cr0);
    end
    sc("R12 no reservation after reset", 0, 32'h0, 32'h0, 32'h1111_1111, 1);
    reserve("R4 reserve", 32'h0000_1008, 0);
    sc("R1 R4 base field zero ignores base", 1, 32'hFFFF_FFFF, 32'h0000_1000, 32'hA1B2_C3D4, 0);
    sc("R6 second attempt fails", 1, 0, 32'h0000_1000, 32'h5555_5555, 1);
    reserve("R2 reserve", 32'h0000_2040, 0);
    sc("R2 other word same line", 0, 32'h0000_2000, 32'h0000_007C, 32'h0BAD_F00D, 1);
    reserve("R2 reserve", 32'h0000_2000, 0);
    sc("R2 next line misses", 0, 32'h0000_2000, 32'h0000_0080, 32'h1, 0);
    reserve("R1 reserve", 32'h0000_0080, 0);
    sc("R1 sum wraps at 32 bits", 0, 32'hFFFF_FF80, 32'h0000_0100, 32'hCAFE_0001, 0);
    reserve("R3 dword reserve", 32'h0000_3000, 1);
    sc("R3 dword reservation fails", 0, 32'h0000_3000, 0, 32'h3, 0);
    reserve("R7 reserve", 32'h0000_4000, 0);
    snoop("R7 snoop other line", 32'h0000_4080);
    sc("R7 outside snoop keeps reservation", 0, 32'h0000_4000, 0, 32'h7777_0000, 0);
    reserve("R7 reserve", 32'h0000_4000, 0);
    snoop("R7 snoop in line", 32'h0000_407C);
    sc("R7 in-line snoop cancels", 0, 32'h0000_4000, 0, 32'h7777_0001, 1);
    reserve("R9 reserve", 32'h0000_5000, 0);
    drive("R9 context switch", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    sc("R9 after context switch", 0, 32'h0000_5000, 0, 32'h9, 0);
    reserve("R10 reserve", 32'h0000_6000, 0);
    drive("R10 snoop same cycle as attempt", 0, 0, 0, 1, 0, 32'h0000_6000, 0, 32'hA, 0, 1, 32'h0000_6010, 0);
    reserve("R10 reserve", 32'h0000_6000, 0);
    drive("R10 ctx same cycle as attempt", 0, 0, 0, 1, 0, 32'h0000_6000, 0, 32'hB, 1, 0, 0, 1);
    reserve("R8 reserve", 32'h0000_6000, 0);
    sc("R8 misaligned faults", 0, 32'h0000_6000, 32'h2, 32'h8, 0);
    sc("R8 reservation gone after fault", 0, 32'h0000_6000, 0, 32'h8, 0);
    reserve("R11 reserve A", 32'h0000_7000, 0);
    reserve("R11 reserve B dword", 32'h0000_8000, 1);
    reserve("R11 reserve C", 32'h0000_9000, 0);
    sc("R11 old line A lost", 0, 32'h0000_7000, 0, 32'h11, 0);
    reserve("R11 dword", 32'h0000_9000, 1);
    reserve("R11 word overwrites dword", 32'h0000_9000, 0);
    sc("R11 word reservation commits", 0, 32'h0000_9000, 32'h4, 32'hDEAD_BEEF, 1);
    reserve("R11 reserve D", 32'h0000_A000, 0);
    drive("R11 reserve with attempt same cycle", 1, 32'h0000_B000, 0, 1, 0, 32'h0000_A000, 0, 32'h12, 0, 0, 0, 0);
    sc("R11 new reservation kept", 0, 32'h0000_B000, 0, 32'h13, 0);
    idle("R4 idle");
    idle("R4 idle");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule